// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

One DMA channel that walks a chain of command descriptors held in memory. Software loads the address of the first descriptor and adds credit to the channel's semaphore counter. For each descriptor the sequencer reads a header of three words and then any register-programming words. Each programming word goes out on a peripheral register port. The sequencer then moves the requested bytes between memory and the peripheral data port. After the last byte it may take one credit back, may pulse a completion interrupt, and either follows the next pointer or goes idle.

The channel never begins a descriptor while the counter is zero. Software can therefore gate a ring of descriptors period by period, adding credit while the channel runs. The current buffer address is visible on a port, so software can work out how many bytes are still to move.

Top module: `dsc_chain_dma`

## Requirements
- R1: A descriptor at address A is read as 32-bit words from A upward: word 0 is the next-descriptor address, word 1 holds the control field in bits 15:0 and the byte count in bits 31:16, word 2 is the buffer address, and words 3 onward are register-programming words.
- R2: The programming-word count sits in control bits 15:12. That many words go out on the register port with index 0, 1, 2 and so on, in order, before any data beat of the same descriptor.
- R3: Control bits 1:0 equal to 1 move bytes from the peripheral to memory. The words are written at rising word addresses from the buffer address. A final beat with n<4 bytes sets only the low n byte enables (bit i enables bits 8i+7:8i).
- R4: Control bits 1:0 equal to 2 read memory at rising word addresses from the buffer address and hand each word to the peripheral write port.
- R5: Command 0 moves no data. Command 3, or a byte count above 0xFF00, raises a one-cycle error pulse. On error, no data moves, no interrupt is raised, the counter and buffer address keep their values, and the channel goes idle. A count of exactly 0xFF00 is legal.
- R6: A write to the semaphore port adds to the 8-bit counter and saturates at 255. The counter is zero after reset. No descriptor fetch begins while the counter is zero.
- R7: The counter drops by exactly one when a descriptor finishes with control bit 6 set, and never otherwise.
- R8: With control bit 2 set, the channel goes on to the descriptor named by word 0, so a pointer back to an earlier descriptor forms a ring. With bit 2 clear, it goes idle and issues no memory requests until the next start address is written.
- R9: With control bit 3 set, `irq` pulses for exactly one cycle after the descriptor's last byte. With control bit 7 also set, the pulse and the rest of the sequence wait until `per_end` is high.
- R10: `cur_buf` loads from descriptor word 2 and advances by the number of bytes moved on each data beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_next_we | input | 1 | Load start descriptor address (taken while idle) |
| cfg_next_addr | input | 32 | Start descriptor address |
| sema_we | input | 1 | Add to semaphore counter |
| sema_add | input | SEMA_W | Amount to add |
| sema_level | output | SEMA_W | Current semaphore count |
| cur_buf | output | 32 | Current buffer address |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte enables |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| pio_we | output | 1 | Register-programming write strobe |
| pio_idx | output | 4 | Register index |
| pio_data | output | 32 | Register value |
| per_wvalid | output | 1 | Data word offered to peripheral |
| per_wready | input | 1 | Peripheral takes the offered word |
| per_wdata | output | 32 | Data word to peripheral |
| per_rvalid | input | 1 | Peripheral offers a data word |
| per_rready | output | 1 | Channel takes the offered word |
| per_rdata | input | 32 | Data word from peripheral |
| per_end | input | 1 | Peripheral end-of-command handshake |
| irq | output | 1 | Completion pulse |
| err | output | 1 | Bad-descriptor pulse |

## Verification
The bench runs a two-descriptor ring with one credit at a time and checks that the channel stops before the next fetch. A sequencer that ignored the counter would run the ring on and emit unexpected register and data events. A 10-byte transfer checks the trailing 2-byte beat: a design with wrong byte enables or a wrong address step would show mismatched memory writes and a wrong final `cur_buf`. A programming-only descriptor with end-wait held off checks that a design not waiting on `per_end` would pulse `irq` early. It also checks that decrementing without the bit set would lower the counter. Finally, command 3 and a 0xFF01 count must raise `err` while 0xFF00 must not, which catches a misplaced limit compare.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
    localparam int ADDR_W    = 32;
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 16;
    localparam int PIO_IDX_W = 4;
    localparam int WIDX_W    = 5;
    localparam logic [CNT_W-1:0] MAX_BYTES = 16'hFF00;

    // positions inside the descriptor control half-word
    localparam int B_CHAIN = 2;
    localparam int B_IRQ   = 3;
    localparam int B_DEC   = 6;
    localparam int B_WEND  = 7;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_P2M  = 2'd1,
        CMD_M2P  = 2'd2,
        CMD_BAD  = 2'd3
    } cmd_e;

    typedef struct packed {
        logic [PIO_IDX_W-1:0] npio;
        logic                 wait_end;
        logic                 dec_sem;
        logic                 irq;
        logic                 chain;
        cmd_e                 cmd;
    } ctrl_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_WAIT, ST_HDR, ST_DATA,
        ST_RDMEM, ST_PUSH, ST_PULL, ST_WRMEM, ST_END
    } st_e;

    function automatic logic [2:0] beat_bytes(logic [CNT_W-1:0] rem);
        return (rem >= CNT_W'(4)) ? 3'd4 : rem[2:0];
    endfunction

    function automatic logic [3:0] beat_mask(logic [2:0] n);
        logic [3:0] m;
        for (int i = 0; i < 4; i++) m[i] = (3'(i) < n);
        return m;
    endfunction
endpackage

// File: rtl/dcd_sema.sv
module dcd_sema
    import dcd_pkg::*;
#(
    parameter int SEMA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              add_we,
    input  logic [SEMA_W-1:0] add_val,
    input  logic              dec,
    output logic [SEMA_W-1:0] count
);
    localparam logic [SEMA_W:0] TOP = {1'b0, {SEMA_W{1'b1}}};

    logic [SEMA_W:0] sum;

    always_comb begin
        sum = {1'b0, count} + (add_we ? {1'b0, add_val} : '0) - {{SEMA_W{1'b0}}, dec};
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= (sum > TOP) ? {SEMA_W{1'b1}} : sum[SEMA_W-1:0];
    end

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!add_we && !dec) |=> count == $past(count));
    a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
        (add_we && !dec && (({1'b0, count} + {1'b0, add_val}) > TOP)) |=> count == {SEMA_W{1'b1}});
    a_r7_dec_nonzero: assert property (@(posedge clk) disable iff (rst)
        dec |-> count != '0);
    a_r7_dec_one: assert property (@(posedge clk) disable iff (rst)
        (dec && !add_we) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/dcd_xfer.sv
module dcd_xfer
    import dcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_cnt,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              ld_buf,
    input  logic [ADDR_W-1:0] buf_val,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_buf,
    output logic [CNT_W-1:0]  rem,
    output logic [3:0]        be
);
    logic [2:0] nbytes;

    always_comb begin
        nbytes = beat_bytes(rem);
        be     = beat_mask(nbytes);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_buf <= '0;
            rem     <= '0;
        end else begin
            if (ld_cnt)    rem <= cnt_val;
            else if (step) rem <= rem - CNT_W'(nbytes);
            if (ld_buf)    cur_buf <= buf_val;
            else if (step) cur_buf <= cur_buf + ADDR_W'(nbytes);
        end
    end

    a_r10_step_live: assert property (@(posedge clk) disable iff (rst)
        step |-> rem != '0);
    a_r10_rem_falls: assert property (@(posedge clk) disable iff (rst)
        (step && !ld_cnt) |=> rem < $past(rem));
endmodule

// File: rtl/dcd_seq.sv
module dcd_seq
    import dcd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_next_we,
    input  logic [ADDR_W-1:0]    cfg_next_addr,
    input  logic                 sema_nz,
    output logic                 sema_dec,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    output logic [3:0]           mem_be,
    input  logic                 mem_ack,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 pio_we,
    output logic [PIO_IDX_W-1:0] pio_idx,
    output logic [WORD_W-1:0]    pio_data,
    output logic                 per_wvalid,
    input  logic                 per_wready,
    output logic [WORD_W-1:0]    per_wdata,
    input  logic                 per_rvalid,
    output logic                 per_rready,
    input  logic [WORD_W-1:0]    per_rdata,
    input  logic                 per_end,
    output logic                 irq,
    output logic                 err,
    output logic                 ld_cnt,
    output logic [CNT_W-1:0]     cnt_val,
    output logic                 ld_buf,
    output logic [ADDR_W-1:0]    buf_val,
    output logic                 step,
    input  logic [CNT_W-1:0]     rem,
    input  logic [ADDR_W-1:0]    cur_buf,
    input  logic [3:0]           beat_be
);
    st_e               st;
    ctrl_t             ctrl, hdr;
    logic [ADDR_W-1:0] desc_addr, next_ptr;
    logic [WIDX_W-1:0] word_idx, last_idx;
    logic [WORD_W-1:0] hold;
    logic              hdr_bad, fin_go;

    always_comb begin
        hdr.cmd      = cmd_e'(mem_rdata[1:0]);
        hdr.chain    = mem_rdata[B_CHAIN];
        hdr.irq      = mem_rdata[B_IRQ];
        hdr.dec_sem  = mem_rdata[B_DEC];
        hdr.wait_end = mem_rdata[B_WEND];
        hdr.npio     = mem_rdata[15:12];
        hdr_bad      = (hdr.cmd == CMD_BAD) || (mem_rdata[31:16] > MAX_BYTES);
        last_idx     = WIDX_W'(2) + WIDX_W'(ctrl.npio);
        fin_go       = (st == ST_END) && (!ctrl.wait_end || per_end);

        mem_req    = (st == ST_HDR) || (st == ST_RDMEM) || (st == ST_WRMEM);
        mem_we     = (st == ST_WRMEM);
        mem_addr   = (st == ST_HDR) ? desc_addr + ADDR_W'({word_idx, 2'b00}) : cur_buf;
        mem_wdata  = hold;
        mem_be     = (st == ST_WRMEM) ? beat_be : 4'hF;
        per_wvalid = (st == ST_PUSH);
        per_wdata  = hold;
        per_rready = (st == ST_PULL);

        ld_cnt   = (st == ST_HDR) && mem_ack && (word_idx == WIDX_W'(1));
        cnt_val  = mem_rdata[31:16];
        ld_buf   = (st == ST_HDR) && mem_ack && (word_idx == WIDX_W'(2));
        buf_val  = mem_rdata;
        step     = ((st == ST_PUSH) && per_wready) || ((st == ST_WRMEM) && mem_ack);
        sema_dec = fin_go && ctrl.dec_sem;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ctrl      <= '0;
            desc_addr <= '0;
            next_ptr  <= '0;
            word_idx  <= '0;
            hold      <= '0;
            pio_we    <= 1'b0;
            pio_idx   <= '0;
            pio_data  <= '0;
            irq       <= 1'b0;
            err       <= 1'b0;
        end else begin
            pio_we <= 1'b0;
            irq    <= 1'b0;
            err    <= 1'b0;
            unique case (st)
                ST_IDLE: if (cfg_next_we) begin
                    desc_addr <= cfg_next_addr;
                    st        <= ST_WAIT;
                end
                ST_WAIT: if (sema_nz) begin
                    word_idx <= '0;
                    st       <= ST_HDR;
                end
                ST_HDR: if (mem_ack) begin
                    if (word_idx == WIDX_W'(0)) next_ptr <= mem_rdata;
                    if (word_idx == WIDX_W'(1)) ctrl <= hdr;
                    if (word_idx >= WIDX_W'(3)) begin
                        pio_we   <= 1'b1;
                        pio_idx  <= PIO_IDX_W'(word_idx - WIDX_W'(3));
                        pio_data <= mem_rdata;
                    end
                    if (word_idx == WIDX_W'(1) && hdr_bad) begin
                        err <= 1'b1;
                        st  <= ST_IDLE;
                    end else if (word_idx >= WIDX_W'(2) && word_idx == last_idx) begin
                        st <= ST_DATA;
                    end else begin
                        word_idx <= word_idx + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (rem == '0 || ctrl.cmd == CMD_NONE) st <= ST_END;
                    else if (ctrl.cmd == CMD_P2M)          st <= ST_PULL;
                    else                                   st <= ST_RDMEM;
                end
                ST_RDMEM: if (mem_ack) begin
                    hold <= mem_rdata;
                    st   <= ST_PUSH;
                end
                ST_PUSH: if (per_wready) st <= ST_DATA;
                ST_PULL: if (per_rvalid) begin
                    hold <= per_rdata;
                    st   <= ST_WRMEM;
                end
                ST_WRMEM: if (mem_ack) st <= ST_DATA;
                ST_END: if (fin_go) begin
                    irq       <= ctrl.irq;
                    desc_addr <= next_ptr;
                    st        <= ctrl.chain ? ST_WAIT : ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    a_r9_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    a_r9_wait_end: assert property (@(posedge clk) disable iff (rst)
        (st == ST_END && ctrl.wait_end && !per_end) |=> !irq);
    a_r6_no_fetch: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && !sema_nz) |=> !mem_req);
    a_r5_err_idle: assert property (@(posedge clk) disable iff (rst)
        err |-> (st == ST_IDLE && !irq));
    a_r3_be_nonzero: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_be != 4'h0);
endmodule

// File: rtl/dsc_chain_dma.sv
module dsc_chain_dma
    import dcd_pkg::*;
#(
    parameter int SEMA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_next_we,
    input  logic [ADDR_W-1:0]    cfg_next_addr,
    input  logic                 sema_we,
    input  logic [SEMA_W-1:0]    sema_add,
    output logic [SEMA_W-1:0]    sema_level,
    output logic [ADDR_W-1:0]    cur_buf,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    output logic [3:0]           mem_be,
    input  logic                 mem_ack,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 pio_we,
    output logic [PIO_IDX_W-1:0] pio_idx,
    output logic [WORD_W-1:0]    pio_data,
    output logic                 per_wvalid,
    input  logic                 per_wready,
    output logic [WORD_W-1:0]    per_wdata,
    input  logic                 per_rvalid,
    output logic                 per_rready,
    input  logic [WORD_W-1:0]    per_rdata,
    input  logic                 per_end,
    output logic                 irq,
    output logic                 err
);
    logic              sema_dec, ld_cnt, ld_buf, step;
    logic [CNT_W-1:0]  cnt_val, rem;
    logic [ADDR_W-1:0] buf_val;
    logic [3:0]        beat_be;

    dcd_sema #(.SEMA_W(SEMA_W)) u_sema (
        .clk(clk), .rst(rst), .add_we(sema_we), .add_val(sema_add),
        .dec(sema_dec), .count(sema_level)
    );

    dcd_xfer u_xfer (
        .clk(clk), .rst(rst), .ld_cnt(ld_cnt), .cnt_val(cnt_val),
        .ld_buf(ld_buf), .buf_val(buf_val), .step(step),
        .cur_buf(cur_buf), .rem(rem), .be(beat_be)
    );

    dcd_seq u_seq (
        .clk(clk), .rst(rst), .cfg_next_we(cfg_next_we), .cfg_next_addr(cfg_next_addr),
        .sema_nz(sema_level != '0), .sema_dec(sema_dec),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .pio_we(pio_we), .pio_idx(pio_idx), .pio_data(pio_data),
        .per_wvalid(per_wvalid), .per_wready(per_wready), .per_wdata(per_wdata),
        .per_rvalid(per_rvalid), .per_rready(per_rready), .per_rdata(per_rdata),
        .per_end(per_end), .irq(irq), .err(err),
        .ld_cnt(ld_cnt), .cnt_val(cnt_val), .ld_buf(ld_buf), .buf_val(buf_val),
        .step(step), .rem(rem), .cur_buf(cur_buf), .beat_be(beat_be)
    );
endmodule

// File: tb/tb_dsc_chain_dma.sv
`timescale 1ns/1ps
module tb_dsc_chain_dma;
    localparam int K_PIO = 0, K_PWR = 1, K_MWR = 2, K_IRQ = 3, K_ERR = 4;

    typedef struct packed {
        logic [2:0]  k;
        logic [31:0] a;
        logic [31:0] d;
        logic [3:0]  be;
    } ev_t;

    logic        clk = 0, rst = 1;
    logic        cfg_next_we = 0, sema_we = 0, per_end = 0;
    logic [31:0] cfg_next_addr = 0;
    logic [7:0]  sema_add = 0, sema_level;
    logic [31:0] cur_buf, mem_addr, mem_wdata, pio_data, per_wdata, per_rdata;
    logic [31:0] mem_rdata = 0;
    logic        mem_req, mem_we, mem_ack = 0, pio_we, per_wvalid, per_rready, irq, err;
    logic        per_wready = 0, per_rvalid = 0;
    logic [3:0]  mem_be, pio_idx;

    logic [31:0] mem [256];
    logic        ld_en = 0;
    logic [31:0] ld_a = 0, ld_d = 0;
    logic [7:0]  src_n = 0;

    int   checks = 0, errors = 0, irq_cnt = 0, err_cnt = 0;
    ev_t  q[$];

    always #2 clk = ~clk;

    dsc_chain_dma dut (
        .clk(clk), .rst(rst), .cfg_next_we(cfg_next_we), .cfg_next_addr(cfg_next_addr),
        .sema_we(sema_we), .sema_add(sema_add), .sema_level(sema_level), .cur_buf(cur_buf),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .pio_we(pio_we), .pio_idx(pio_idx), .pio_data(pio_data),
        .per_wvalid(per_wvalid), .per_wready(per_wready), .per_wdata(per_wdata),
        .per_rvalid(per_rvalid), .per_rready(per_rready), .per_rdata(per_rdata),
        .per_end(per_end), .irq(irq), .err(err)
    );

    // memory model: one acknowledge per request, a cycle after it appears
    always @(posedge clk) begin
        if (ld_en) mem[ld_a[9:2]] <= ld_d;
        if (rst) mem_ack <= 1'b0;
        else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_rdata <= mem[mem_addr[9:2]];
                if (mem_we)
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end
        end
    end

    // peripheral model: throttled handshakes and a counting data source
    assign per_rdata = 32'hA500_0000 | {24'd0, src_n};
    always @(posedge clk) begin
        if (rst) begin
            src_n <= 0; per_wready <= 0; per_rvalid <= 0;
        end else begin
            per_wready <= ~per_wready;
            per_rvalid <= ~per_rvalid;
            if (per_rready && per_rvalid) src_n <= src_n + 1'b1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic observe(input int k, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        ev_t e;
        string tag;
        tag = (k == K_PIO) ? "R2" : (k == K_PWR) ? "R4" : (k == K_MWR) ? "R3" : (k == K_IRQ) ? "R9" : "R5";
        if (q.size() == 0) begin
            check(0, {tag, " unexpected event kind"}, k, 32'hFFFF_FFFF);
            return;
        end
        e = q.pop_front();
        check(e.k == 3'(k), {tag, " event kind"}, k, e.k);
        if (e.k == 3'(k)) begin
            check(e.a == a && e.d == d, {tag, " event data"}, d, e.d);
            check(e.be == be, {tag, " byte enables"}, be, e.be);
            check(e.a == a, {tag, " event address/index"}, a, e.a);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) if (!rst) begin
        if (pio_we) observe(K_PIO, {28'd0, pio_idx}, pio_data, 4'hF);
        if (per_wvalid && per_wready) observe(K_PWR, 0, per_wdata, 4'hF);
        if (mem_req && mem_we && mem_ack) observe(K_MWR, mem_addr, mem_wdata, mem_be);
        if (irq) begin irq_cnt++; observe(K_IRQ, 0, 0, 4'hF); end
        if (err) begin err_cnt++; observe(K_ERR, 0, 0, 4'hF); end
    end

    task automatic expect_ev(input int k, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        ev_t e;
        e.k = 3'(k); e.a = a; e.d = d; e.be = be;
        q.push_back(e);
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); ld_en = 1; ld_a = a; ld_d = d;
        @(negedge clk); ld_en = 0;
    endtask

    task automatic start_at(input logic [31:0] a);
        @(negedge clk); cfg_next_we = 1; cfg_next_addr = a;
        @(negedge clk); cfg_next_we = 0;
    endtask

    task automatic credit(input logic [7:0] v);
        @(negedge clk); sema_we = 1; sema_add = v;
        @(negedge clk); sema_we = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 3000 && q.size() != 0; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        check(q.size() == 0, {tag, " expected events all seen"}, q.size(), 0);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        // descriptors (R1 layout): next, {count, ctrl}, buffer, programming words
        poke(32'h100, 32'h140); poke(32'h104, {16'd10, 16'h2045}); poke(32'h108, 32'h200);
        poke(32'h10C, 32'h1111_0000); poke(32'h110, 32'h2222_0001);
        poke(32'h140, 32'h100); poke(32'h144, {16'd8, 16'h004E}); poke(32'h148, 32'h300);
        poke(32'h300, 32'hCAFE_0000); poke(32'h304, 32'hCAFE_0001);
        poke(32'h180, 32'h0); poke(32'h184, {16'd0, 16'h3088}); poke(32'h188, 32'h2AC);
        poke(32'h18C, 32'hB000_0000); poke(32'h190, 32'hB000_0001); poke(32'h194, 32'hB000_0002);
        poke(32'h1C0, 32'h0); poke(32'h1C4, {16'd4, 16'h0047}); poke(32'h1C8, 32'h200);
        poke(32'h1E0, 32'h0); poke(32'h1E4, {16'hFF01, 16'h0045}); poke(32'h1E8, 32'h200);
        poke(32'h1F0, 32'h0); poke(32'h1F4, {16'hFF00, 16'h0008}); poke(32'h1F8, 32'h250);
        do_reset();

        // reset state
        @(negedge clk);
        check(sema_level == 0, "R6 counter zero after reset", sema_level, 0);
        check(cur_buf == 0, "R10 buffer address zero after reset", cur_buf, 0);
        check(!irq && !err && !mem_req, "R8 quiet after reset", {irq, err, mem_req}, 0);

        // R6 additive writes and saturation
        credit(8'd200);
        check(sema_level == 200, "R6 add from zero", sema_level, 200);
        credit(8'd100);
        check(sema_level == 255, "R6 saturate at 255", sema_level, 255);
        do_reset();

        // ring of two descriptors, gated one credit at a time (R1 R2 R3 R8)
        expect_ev(K_PIO, 0, 32'h1111_0000, 4'hF);
        expect_ev(K_PIO, 1, 32'h2222_0001, 4'hF);
        expect_ev(K_MWR, 32'h200, 32'hA500_0000, 4'hF);
        expect_ev(K_MWR, 32'h204, 32'hA500_0001, 4'hF);
        expect_ev(K_MWR, 32'h208, 32'hA500_0002, 4'h3);
        start_at(32'h100);
        repeat (10) @(negedge clk);
        check(!mem_req && q.size() == 5, "R6 no fetch while counter is zero", q.size(), 5);
        credit(8'd1);
        drain("R3");
        repeat (30) @(negedge clk);
        check(sema_level == 0, "R7 decrement after first descriptor", sema_level, 0);
        check(cur_buf == 32'h20A, "R10 buffer address after 10 bytes", cur_buf, 32'h20A);
        check(!mem_req, "R6 stalled before second descriptor", mem_req, 0);

        expect_ev(K_PWR, 0, 32'hCAFE_0000, 4'hF);
        expect_ev(K_PWR, 0, 32'hCAFE_0001, 4'hF);
        expect_ev(K_IRQ, 0, 0, 4'hF);
        credit(8'd1);
        drain("R4");
        repeat (40) @(negedge clk);
        check(irq_cnt == 1, "R9 one interrupt for ring pass", irq_cnt, 1);
        check(sema_level == 0 && !mem_req, "R8 ring wraps and stalls on zero credit", sema_level, 0);
        check(cur_buf == 32'h308, "R10 buffer address after read pass", cur_buf, 32'h308);
        do_reset();
        irq_cnt = 0;

        // programming-only descriptor with end wait, no decrement, no chain
        expect_ev(K_PIO, 0, 32'hB000_0000, 4'hF);
        expect_ev(K_PIO, 1, 32'hB000_0001, 4'hF);
        expect_ev(K_PIO, 2, 32'hB000_0002, 4'hF);
        expect_ev(K_IRQ, 0, 0, 4'hF);
        credit(8'd1);
        start_at(32'h180);
        repeat (40) @(negedge clk);
        check(irq_cnt == 0 && q.size() == 1, "R9 interrupt held until end handshake", irq_cnt, 0);
        per_end = 1;
        repeat (10) @(negedge clk);
        per_end = 0;
        check(irq_cnt == 1, "R9 interrupt after end handshake", irq_cnt, 1);
        check(sema_level == 1, "R7 no decrement without bit 6", sema_level, 1);
        check(cur_buf == 32'h2AC, "R10 buffer loaded, nothing moved", cur_buf, 32'h2AC);
        check(!mem_req, "R8 idle after unchained descriptor", mem_req, 0);

        // bad command and over-limit count
        expect_ev(K_ERR, 0, 0, 4'hF);
        start_at(32'h1C0);
        drain("R5");
        check(sema_level == 1 && cur_buf == 32'h2AC, "R5 command 3 changes nothing", sema_level, 1);
        expect_ev(K_ERR, 0, 0, 4'hF);
        start_at(32'h1E0);
        drain("R5");
        check(err_cnt == 2 && sema_level == 1, "R5 count 0xFF01 rejected", err_cnt, 2);
        expect_ev(K_IRQ, 0, 0, 4'hF);
        start_at(32'h1F0);
        drain("R5");
        check(err_cnt == 2 && cur_buf == 32'h250, "R5 count 0xFF00 accepted", cur_buf, 32'h250);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule